// File: doc/BRIEF.md
# Variable-Length Instruction Length Decoder (16-bit x86 subset)

This block walks a stream of 16-bit x86 machine code, taking one byte per cycle, and cuts it into whole instructions. For each instruction it emits one record carrying the opcode, the three ModR/M fields, the displacement, the immediate and the total byte count. An instruction's length is not known from its first byte. The opcode decides whether a ModR/M byte follows. The mode field of that byte then decides how many displacement bytes come before the immediate.

Two opcode families are understood. The first is the one-byte register push, 0x50 through 0x57. The second is the group opcode 0x81, which takes a ModR/M byte, an optional displacement and a 16-bit immediate. Any other first byte is reported as a one-byte invalid record, and parsing restarts with the next byte.

Both edges are valid/ready streams. A byte moves when `in_valid` and `in_ready` are both high at a rising edge. A record moves when `out_valid` and `out_ready` are both high. There is one record slot. While a record is waiting, `in_ready` is low and the record's fields do not change. The cycle after the record is taken, `in_ready` rises again. The producer may insert idle cycles between any two bytes. The consumer may hold `out_ready` low for any number of cycles.

Top module: `insn_len_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A first byte from 0x50 to 0x57 yields a record with length 1, `out_reg` equal to the byte's low three bits (0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI), `out_mod` = 3, `out_has_modrm` = 0, and zero displacement and immediate.
- R3: For opcode 0x81, the byte after the opcode is split as mod = bits 7:6, reg = bits 5:3 and r/m = bits 2:0, and `out_has_modrm` is 1.
- R4: mod = 0 with r/m other than 6 takes no displacement. The displacement reads 0 and the length is 4.
- R5: mod = 1 takes one displacement byte, sign-extended to 16 bits. The length is 5.
- R6: mod = 2 takes two displacement bytes, low byte first. The length is 6.
- R7: mod = 0 with r/m = 6 is a direct address and takes two displacement bytes, low byte first. The length is 6.
- R8: mod = 3 names a register operand and takes no displacement. The length is 4.
- R9: The 16-bit immediate of opcode 0x81 comes last, low byte first. For example, 0x81 0xFA 0xCD 0xAB gives reg 7, r/m 2, immediate 0xABCD and length 4.
- R10: Any other first byte gives a record with `out_bad` = 1, length 1 and that opcode. The next byte is then parsed as a new opcode.
- R11: While `out_valid` is high and `out_ready` is low, the record stays valid and unchanged, and `in_ready` is low. A byte held on the input during that time is accepted only after the record is taken, and it is not lost.
- R12: Idle cycles between the bytes of an instruction do not change the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_byte | input | 8 | Input code byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Record is valid |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | First byte of the instruction |
| out_mod | output | 2 | Mode field (3 for a push) |
| out_reg | output | 3 | Reg field, or the push register |
| out_rm | output | 3 | r/m field |
| out_has_modrm | output | 1 | A ModR/M byte was present |
| out_disp | output | 16 | Displacement, sign-extended when one byte |
| out_imm | output | 16 | Immediate |
| out_len | output | 3 | Instruction length in bytes, 1 to 6 |
| out_bad | output | 1 | Opcode outside the supported subset |

## Verification
Two things can fall in the same cycle: the consumer taking a pending record, and the producer presenting the first byte of the next instruction. The bench holds a push opcode on the input while a record is stalled. It then checks three things. First, `in_ready` stays low and the record stays frozen. Second, the record is released. Third, the held byte comes out as its own correct record one cycle later, so it was neither dropped nor merged into the old record. Random traffic repeats this pattern with random idle gaps and random consumer stalls. Every record is compared against a reference parser written in the bench.

// File: rtl/insn_len_pkg.sv
package insn_len_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int LEN_W  = 3;
  localparam int DCNT_W = 2;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_DLO, ST_DHI, ST_ILO, ST_IHI
  } parse_st_e;

  typedef enum logic [1:0] {
    OC_BAD, OC_PUSH, OC_GRP
  } opc_kind_e;
endpackage

// File: rtl/insn_opc_class.sv
module insn_opc_class
  import insn_len_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PUSH_BASE = 8'h50,
  parameter logic [BYTE_W-1:0] GRP_OPC   = 8'h81
) (
  input  logic [BYTE_W-1:0] opc,
  output opc_kind_e         kind,
  output logic [2:0]        push_reg
);
  always_comb begin
    push_reg = opc[2:0];
    if (opc[BYTE_W-1:3] == PUSH_BASE[BYTE_W-1:3]) kind = OC_PUSH;
    else if (opc == GRP_OPC)                     kind = OC_GRP;
    else                                         kind = OC_BAD;
  end
endmodule

// File: rtl/insn_modrm_disp.sv
module insn_modrm_disp
  import insn_len_pkg::*;
#(
  parameter logic [2:0] DIRECT_RM = 3'b110
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        rm,
  output logic [DCNT_W-1:0] disp_bytes
);
  always_comb begin
    unique case (mode)
      2'b00:   disp_bytes = (rm == DIRECT_RM) ? DCNT_W'(2) : DCNT_W'(0);
      2'b01:   disp_bytes = DCNT_W'(1);
      2'b10:   disp_bytes = DCNT_W'(2);
      default: disp_bytes = DCNT_W'(0);
    endcase
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import insn_len_pkg::*;
#(
  parameter logic [BYTE_W-1:0] PUSH_BASE = 8'h50,
  parameter logic [BYTE_W-1:0] GRP_OPC   = 8'h81,
  parameter logic [2:0]        DIRECT_RM = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_opcode,
  output logic [1:0]        out_mod,
  output logic [2:0]        out_reg,
  output logic [2:0]        out_rm,
  output logic              out_has_modrm,
  output logic [WORD_W-1:0] out_disp,
  output logic [WORD_W-1:0] out_imm,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_bad
);
  parse_st_e          st_q;
  opc_kind_e          kind;
  logic [2:0]         push_reg;
  logic [DCNT_W-1:0]  dcnt_w, dcnt_q;
  logic               accept;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  insn_opc_class #(.PUSH_BASE(PUSH_BASE), .GRP_OPC(GRP_OPC)) u_cls (
    .opc(in_byte), .kind(kind), .push_reg(push_reg)
  );

  insn_modrm_disp #(.DIRECT_RM(DIRECT_RM)) u_dsp (
    .mode(in_byte[7:6]), .rm(in_byte[2:0]), .disp_bytes(dcnt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= ST_OPC;
      dcnt_q        <= '0;
      out_valid     <= 1'b0;
      out_opcode    <= '0;
      out_mod       <= '0;
      out_reg       <= '0;
      out_rm        <= '0;
      out_has_modrm <= 1'b0;
      out_disp      <= '0;
      out_imm       <= '0;
      out_len       <= '0;
      out_bad       <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (accept) begin
        out_len <= (st_q == ST_OPC) ? LEN_W'(1) : out_len + LEN_W'(1);
        unique case (st_q)
          ST_OPC: begin
            out_opcode    <= in_byte;
            out_mod       <= '0;
            out_reg       <= '0;
            out_rm        <= '0;
            out_has_modrm <= 1'b0;
            out_disp      <= '0;
            out_imm       <= '0;
            out_bad       <= 1'b0;
            unique case (kind)
              OC_PUSH: begin
                out_mod   <= 2'b11;
                out_reg   <= push_reg;
                out_valid <= 1'b1;
              end
              OC_GRP:  st_q <= ST_MODRM;
              default: begin
                out_bad   <= 1'b1;
                out_valid <= 1'b1;
              end
            endcase
          end
          ST_MODRM: begin
            out_mod       <= in_byte[7:6];
            out_reg       <= in_byte[5:3];
            out_rm        <= in_byte[2:0];
            out_has_modrm <= 1'b1;
            dcnt_q        <= dcnt_w;
            st_q          <= (dcnt_w == '0) ? ST_ILO : ST_DLO;
          end
          ST_DLO: begin
            out_disp <= (dcnt_q == DCNT_W'(1))
                        ? {{(WORD_W-BYTE_W){in_byte[BYTE_W-1]}}, in_byte}
                        : {{(WORD_W-BYTE_W){1'b0}}, in_byte};
            st_q     <= (dcnt_q == DCNT_W'(2)) ? ST_DHI : ST_ILO;
          end
          ST_DHI: begin
            out_disp[WORD_W-1:BYTE_W] <= in_byte;
            st_q                      <= ST_ILO;
          end
          ST_ILO: begin
            out_imm[BYTE_W-1:0] <= in_byte;
            st_q                <= ST_IHI;
          end
          ST_IHI: begin
            out_imm[WORD_W-1:BYTE_W] <= in_byte;
            out_valid                <= 1'b1;
            st_q                     <= ST_OPC;
          end
          default: st_q <= ST_OPC;
        endcase
      end
    end
  end
endmodule

// File: rtl/insn_len_decoder_chk.sv
module insn_len_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [7:0]  in_byte,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_opcode,
  input logic [1:0]  out_mod,
  input logic [2:0]  out_reg,
  input logic [2:0]  out_rm,
  input logic        out_has_modrm,
  input logic [15:0] out_disp,
  input logic [15:0] out_imm,
  input logic [2:0]  out_len,
  input logic        out_bad
);
  logic [2:0] grp_len;
  always_comb begin
    if (out_mod == 2'b01)                              grp_len = 3'd5;
    else if (out_mod == 2'b10)                         grp_len = 3'd6;
    else if (out_mod == 2'b00 && out_rm == 3'b110)     grp_len = 3'd6;
    else                                               grp_len = 3'd4;
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_mod)
      && $stable(out_reg) && $stable(out_rm) && $stable(out_disp) && $stable(out_imm)
      && $stable(out_len) && $stable(out_bad) && $stable(out_has_modrm));

  // R11
  no_take_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_bad |-> out_len == 3'd1 && !out_has_modrm);

  // R2
  push_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bad && !out_has_modrm |-> out_len == 3'd1 && out_mod == 2'b11);

  // R4 R5 R6 R7 R8
  grp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_has_modrm |-> out_len == grp_len);

  // R5
  short_disp_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_has_modrm && out_mod == 2'b01 |-> out_disp[15:8] == {8{out_disp[7]}});
endmodule

bind insn_len_decoder insn_len_decoder_chk u_chk (.*);

// File: tb/insn_len_decoder_bench.sv
`timescale 1ns/1ps
module insn_len_decoder_bench;
  typedef struct packed {
    logic [7:0]  opc;
    logic [1:0]  md;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic        hm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic [2:0]  len;
    logic        bad;
  } rec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_opcode;
  logic [1:0] out_mod;
  logic [2:0] out_reg, out_rm, out_len;
  logic out_has_modrm, out_bad;
  logic [15:0] out_disp, out_imm;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  insn_len_decoder u_insn_len_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm),
    .out_has_modrm(out_has_modrm), .out_disp(out_disp), .out_imm(out_imm),
    .out_len(out_len), .out_bad(out_bad)
  );

  function automatic rec_t cur();
    return '{opc: out_opcode, md: out_mod, rg: out_reg, rm: out_rm, hm: out_has_modrm,
             disp: out_disp, imm: out_imm, len: out_len, bad: out_bad};
  endfunction

  function automatic rec_t model(input logic [7:0] b [6]);
    rec_t r = '0;
    int k;
    r.opc = b[0];
    r.len = 3'd1;
    if (b[0][7:3] == 5'b01010) begin
      r.md = 2'b11;
      r.rg = b[0][2:0];
    end else if (b[0] == 8'h81) begin
      r.hm = 1'b1;
      r.md = b[1][7:6];
      r.rg = b[1][5:3];
      r.rm = b[1][2:0];
      k = 2;
      if (r.md == 2'b01) begin
        r.disp = {{8{b[2][7]}}, b[2]};
        k = 3;
      end else if (r.md == 2'b10 || (r.md == 2'b00 && r.rm == 3'b110)) begin
        r.disp = {b[3], b[2]};
        k = 4;
      end
      r.imm = {b[k+1], b[k]};
      r.len = 3'(k + 2);
    end else begin
      r.bad = 1'b1;
    end
    return r;
  endfunction

  task automatic chk_rec(input bit ok, input string req, input rec_t act, input rec_t exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input bit ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drives one byte; returns at the falling edge after it was accepted.
  task automatic put_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b [6], input int n, input int gapmax);
    for (int i = 0; i < n; i++) begin
      if (gapmax > 0) begin
        int g = $urandom_range(0, gapmax);
        if (g > 0) begin
          in_valid = 1'b0;
          repeat (g) @(negedge clk);
        end
      end
      put_byte(b[i]);
    end
    in_valid = 1'b0;
  endtask

  task automatic take(input rec_t exp, input string req, input int hold);
    while (!out_valid) @(negedge clk);
    for (int h = 0; h < hold; h++) begin
      chk_rec(out_valid && !in_ready && cur() == exp, {req, " R11 held"}, cur(), exp);
      @(negedge clk);
    end
    chk_rec(out_valid && cur() == exp, req, cur(), exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk_bit(!out_valid, {req, " R11 released"}, out_valid, 1'b0);
  endtask

  task automatic run(input logic [7:0] b [6], input rec_t exp, input string req,
                     input int gapmax, input int hold);
    send(b, int'(exp.len), gapmax);
    take(exp, req, hold);
  endtask

  function automatic rec_t grp(input logic [7:0] m, input logic [15:0] d,
                               input logic [15:0] i, input int len);
    return '{opc: 8'h81, md: m[7:6], rg: m[5:3], rm: m[2:0], hm: 1'b1,
             disp: d, imm: i, len: 3'(len), bad: 1'b0};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] b [6];
    rec_t e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_bit(!out_valid, "R1 out_valid", out_valid, 1'b0);
    chk_bit(in_ready, "R1 in_ready", in_ready, 1'b1);

    // R2: all eight push registers
    for (int r = 0; r < 8; r++) begin
      b = '{8'h50 + 8'(r), 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
      e = '{opc: 8'h50 + 8'(r), md: 2'b11, rg: 3'(r), rm: 3'd0, hm: 1'b0,
            disp: 16'h0, imm: 16'h0, len: 3'd1, bad: 1'b0};
      run(b, e, "R2 push", 0, r % 3);
    end

    // R8 R9 R3: register compare DX with 0xABCD
    b = '{8'h81, 8'hFA, 8'hCD, 8'hAB, 8'h00, 8'h00};
    run(b, grp(8'hFA, 16'h0000, 16'hABCD, 4), "R8 R9 R3 reg-imm", 0, 1);
    // R5: [BP+8]
    b = '{8'h81, 8'h7E, 8'h08, 8'hCD, 8'hAB, 8'h00};
    run(b, grp(8'h7E, 16'h0008, 16'hABCD, 5), "R5 disp8 positive", 0, 0);
    // R5: negative byte displacement
    b = '{8'h81, 8'h7E, 8'hF0, 8'h34, 8'h12, 8'h00};
    run(b, grp(8'h7E, 16'hFFF0, 16'h1234, 5), "R5 disp8 negative", 1, 2);
    // R6
    b = '{8'h81, 8'hBF, 8'h34, 8'h12, 8'h78, 8'h56};
    run(b, grp(8'hBF, 16'h1234, 16'h5678, 6), "R6 disp16", 0, 0);
    // R7: direct address
    b = '{8'h81, 8'h3E, 8'h00, 8'h80, 8'h01, 8'h00};
    run(b, grp(8'h3E, 16'h8000, 16'h0001, 6), "R7 direct", 0, 0);
    // R4
    b = '{8'h81, 8'h38, 8'h11, 8'h22, 8'h00, 8'h00};
    run(b, grp(8'h38, 16'h0000, 16'h2211, 4), "R4 no disp", 0, 0);
    // R12: same instruction with idle gaps
    b = '{8'h81, 8'hBF, 8'h34, 8'h12, 8'h78, 8'h56};
    run(b, grp(8'hBF, 16'h1234, 16'h5678, 6), "R12 gaps", 3, 0);

    // R10: unsupported opcode, then the next byte is an opcode
    b = '{8'h0F, 8'h55, 8'h0, 8'h0, 8'h0, 8'h0};
    e = '{opc: 8'h0F, md: 2'b00, rg: 3'd0, rm: 3'd0, hm: 1'b0,
          disp: 16'h0, imm: 16'h0, len: 3'd1, bad: 1'b1};
    run(b, e, "R10 bad opcode", 0, 1);
    b = '{8'h55, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    e = '{opc: 8'h55, md: 2'b11, rg: 3'd5, rm: 3'd0, hm: 1'b0,
          disp: 16'h0, imm: 16'h0, len: 3'd1, bad: 1'b0};
    run(b, e, "R10 resume", 0, 0);

    // R11: next byte held on the input while a record waits, then pop
    b = '{8'h81, 8'hFA, 8'hCD, 8'hAB, 8'h00, 8'h00};
    send(b, 4, 0);
    in_valid = 1'b1;
    in_byte  = 8'h53;
    @(negedge clk);
    @(negedge clk);
    chk_rec(out_valid && !in_ready && cur() == grp(8'hFA, 16'h0, 16'hABCD, 4),
            "R11 stall with input waiting", cur(), grp(8'hFA, 16'h0, 16'hABCD, 4));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk_bit(in_ready, "R11 ready after pop", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    e = '{opc: 8'h53, md: 2'b11, rg: 3'd3, rm: 3'd0, hm: 1'b0,
          disp: 16'h0, imm: 16'h0, len: 3'd1, bad: 1'b0};
    take(e, "R11 held byte decoded", 0);

    // Random mix, R2 to R12
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      for (int i = 0; i < 6; i++) b[i] = 8'($urandom_range(0, 255));
      if (sel < 2)      b[0] = 8'h50 + 8'($urandom_range(0, 7));
      else if (sel < 9) b[0] = 8'h81;
      else begin
        while (b[0][7:3] == 5'b01010 || b[0] == 8'h81) b[0] = 8'($urandom_range(0, 255));
      end
      e = model(b);
      run(b, e, "R2-R12 random mix (R12 gaps, R11 stalls)", 2, $urandom_range(0, 3));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule